// File: doc/BRIEF.md
# Windowed Tone-Tracking Digital PLL

This block is a sampled, all-digital phase-locked loop that follows a single sinusoidal tone. Each time a new signed sample is presented, a multiplying phase detector forms an error from that sample and a square-wave reference. The reference is the sign of the quadrature phase of a phase-accumulator oscillator. A proportional-plus-integral loop filter turns the error into a frequency offset. That offset is added to a fixed centre word to form the oscillator's frequency word.

The frequency offset is held inside a narrow window around the expected tone. Every sample, the updated integrator is tested against that window. If its frequency offset falls outside, the integrator is reloaded to the upper window edge in the same cycle. The loop then sweeps the window again instead of drifting across the whole oscillator range.

A lock indicator watches a low-pass filtered copy of the phase error. It asserts after the magnitude of that filtered error has stayed small for a set number of samples. All gains, the window, the lock filter and the lock count are parameters.

Top module: `dpll_tone_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, the phase becomes 0, the frequency word becomes CENTER_WORD + HALF_WORD, the integrator is loaded with HALF_WORD << FRAC_W and `locked` becomes 0.
- R2: A clock edge with `inValid` low leaves `phaseOut`, `freqWord` and `locked` unchanged, whatever `inSample` holds.
- R3: A clock edge with `inValid` high adds the frequency word held before that edge to the phase, modulo 2^PHASE_W.
- R4: The phase error is +inSample when the two most significant phase bits are equal (00 or 11), and -inSample when they differ (01 or 10).
- R5: On a valid sample, the integrator candidate is integ + KI_GAIN*err. The new frequency word is CENTER_WORD + ((newInteg + KP_GAIN*err) >>> FRAC_W), using arithmetic shifts.
- R6: The frequency offset written into `freqWord` is clamped to the range [-HALF_WORD, +HALF_WORD].
- R7: When (candidate >>> FRAC_W) is above HALF_WORD or below -HALF_WORD, the integrator takes HALF_WORD << FRAC_W in that same sample, and the word is computed from the reloaded value.
- R8: The lock filter updates as lp += (err - lp) >>> LOCK_SHIFT. `locked` rises on the valid sample that completes LOCK_COUNT consecutive valid samples in which the updated |lp| is below LOCK_THRESH, counted from reset or from the last event that cleared it.
- R9: A valid sample that causes a window reload clears `locked` and restarts the lock count.
- R10: A valid sample whose updated |lp| is at least LOCK_THRESH clears `locked` and restarts the lock count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | One-cycle strobe marking a new input sample |
| inSample | input | SAMPLE_W | Signed input sample |
| phaseOut | output | PHASE_W | Oscillator phase accumulator |
| freqWord | output | PHASE_W | Frequency control word driving the oscillator |
| locked | output | 1 | Lock indicator |

## Verification
The assertions assume a window that stays clear of wrap-around: CENTER_WORD - HALF_WORD is not negative, and CENTER_WORD + HALF_WORD fits in PHASE_W bits. They also assume the accumulator width has enough headroom that the integrator plus one gained error product never overflows. The bench keeps within these assumptions. It uses a small centre and window, samples of at most 256 in magnitude, and gains of a few units. It picks the sign of each sample from the observed phase, so the error it wants reaches the detector. This is how it drives the integrator across the whole window to the lower edge.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

  // Strobes issued by the control unit to the datapath each cycle
  typedef struct packed {
    logic step;    // accept the sample presented this cycle
    logic reload;  // integrator escaped the window: load the upper edge
  } dpllStrobes_t;

endpackage

// File: rtl/dpll_datapath.sv
module dpll_datapath
  import dpll_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int PHASE_W     = 16,
  parameter int FRAC_W      = 8,
  parameter int CENTER_WORD = 15135,
  parameter int HALF_WORD   = 887,
  parameter int KP_GAIN     = 64,
  parameter int KI_GAIN     = 4,
  parameter int ACC_W       = PHASE_W + FRAC_W + SAMPLE_W + 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  dpllStrobes_t               strb,
  input  logic signed [SAMPLE_W-1:0] inSample,
  output logic        [PHASE_W-1:0]  phase,
  output logic        [PHASE_W-1:0]  freqWord,
  output logic signed [SAMPLE_W:0]   phaseErr,
  output logic signed [ACC_W-1:0]    sumOffset
);

  localparam int ERR_W = SAMPLE_W + 1;
  localparam logic signed [ACC_W-1:0] HALF_S   = ACC_W'(HALF_WORD);
  localparam logic signed [ACC_W-1:0] UPPER_S  = HALF_S <<< FRAC_W;
  localparam logic signed [ACC_W-1:0] BOUND_S  = (HALF_S + 1) <<< FRAC_W;
  localparam logic signed [ACC_W-1:0] KP_S     = ACC_W'(KP_GAIN);
  localparam logic signed [ACC_W-1:0] KI_S     = ACC_W'(KI_GAIN);
  localparam logic        [PHASE_W-1:0] CENTER_U = PHASE_W'(CENTER_WORD);
  localparam logic        [PHASE_W-1:0] HALF_U   = PHASE_W'(HALF_WORD);

  logic signed [ACC_W-1:0] integ;
  logic signed [ACC_W-1:0] errAcc;
  logic signed [ACC_W-1:0] integSum;
  logic signed [ACC_W-1:0] integNext;
  logic signed [ACC_W-1:0] filtOffset;
  logic signed [ACC_W-1:0] clampOffset;
  logic        [PHASE_W-1:0] freqNext;
  logic        refPos;
  logic signed [ERR_W-1:0] sampleExt;

  // Square-wave quadrature reference from the two top phase bits
  assign refPos    = (phase[PHASE_W-1] == phase[PHASE_W-2]);
  assign sampleExt = {inSample[SAMPLE_W-1], inSample};
  assign phaseErr  = refPos ? sampleExt : -sampleExt;
  assign errAcc    = {{(ACC_W-ERR_W){phaseErr[ERR_W-1]}}, phaseErr};

  // Integral path and its window test value
  assign integSum  = integ + KI_S * errAcc;
  assign sumOffset = integSum >>> FRAC_W;
  assign integNext = strb.reload ? UPPER_S : integSum;

  // Proportional path added on top of the updated integrator
  assign filtOffset = (integNext + KP_S * errAcc) >>> FRAC_W;

  always_comb begin
    if (filtOffset > HALF_S)       clampOffset = HALF_S;
    else if (filtOffset < -HALF_S) clampOffset = -HALF_S;
    else                           clampOffset = filtOffset;
  end

  assign freqNext = CENTER_U + clampOffset[PHASE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      integ    <= UPPER_S;
      freqWord <= CENTER_U + HALF_U;
    end else if (strb.step) begin
      phase    <= phase + freqWord;
      integ    <= integNext;
      freqWord <= freqNext;
    end
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    strb.step |=> (phase == PHASE_W'($past(phase) + $past(freqWord)))); // R3

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.step |=> ($stable(phase) && $stable(freqWord))); // R2

  AST_WORD_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (freqWord >= CENTER_U - HALF_U) && (freqWord <= CENTER_U + HALF_U)); // R6

  AST_INTEG_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (integ < BOUND_S) && (integ >= -UPPER_S)); // R7

  AST_RELOAD_UPPER: assert property (@(posedge clk) disable iff (rst)
    (strb.step && strb.reload) |=> (integ == UPPER_S)); // R7

endmodule

// File: rtl/dpll_control.sv
module dpll_control
  import dpll_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int PHASE_W     = 16,
  parameter int FRAC_W      = 8,
  parameter int HALF_WORD   = 887,
  parameter int LOCK_SHIFT  = 4,
  parameter int LOCK_THRESH = 64,
  parameter int LOCK_COUNT  = 256,
  parameter int ACC_W       = PHASE_W + FRAC_W + SAMPLE_W + 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [SAMPLE_W:0] phaseErr,
  input  logic signed [ACC_W-1:0]  sumOffset,
  output dpllStrobes_t             strb,
  output logic                     locked
);

  localparam int ERR_W = SAMPLE_W + 1;
  localparam int LP_W  = ERR_W + 2;
  localparam int CNT_W = $clog2(LOCK_COUNT + 1);
  localparam logic signed [ACC_W-1:0] HALF_S   = ACC_W'(HALF_WORD);
  localparam logic signed [LP_W-1:0]  THRESH_S = LP_W'(LOCK_THRESH);
  localparam logic        [CNT_W-1:0] LAST_CNT = CNT_W'(LOCK_COUNT - 1);

  logic signed [LP_W-1:0] lp;
  logic signed [LP_W-1:0] lpNext;
  logic signed [LP_W-1:0] lpDiff;
  logic signed [LP_W-1:0] lpMag;
  logic        [CNT_W-1:0] quietCnt;
  logic        outOfWindow;
  logic        quiet;

  // Window monitor on the candidate integrator value
  assign outOfWindow = (sumOffset > HALF_S) || (sumOffset < -HALF_S);
  assign strb.step   = inValid;
  assign strb.reload = inValid && outOfWindow;

  // First-order low-pass of the phase error for lock detection
  assign lpDiff = {{(LP_W-ERR_W){phaseErr[ERR_W-1]}}, phaseErr} - lp;
  assign lpNext = lp + (lpDiff >>> LOCK_SHIFT);
  assign lpMag  = lpNext[LP_W-1] ? -lpNext : lpNext;
  assign quiet  = lpMag < THRESH_S;

  always_ff @(posedge clk) begin
    if (rst) begin
      lp       <= '0;
      quietCnt <= '0;
      locked   <= 1'b0;
    end else if (inValid) begin
      lp <= lpNext;
      if (strb.reload || !quiet) begin
        quietCnt <= '0;
        locked   <= 1'b0;
      end else if (!locked) begin
        if (quietCnt == LAST_CNT) locked   <= 1'b1;
        else                      quietCnt <= quietCnt + 1'b1;
      end
    end
  end

  AST_RELOAD_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
    strb.reload |=> !locked); // R9

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(locked)); // R2

  AST_LOCK_RISE_QUIET: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(inValid && !strb.reload)); // R8

  AST_LOUD_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
    (inValid && !quiet) |=> !locked); // R10

endmodule

// File: rtl/dpll_tone_tracker.sv
module dpll_tone_tracker
  import dpll_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int PHASE_W     = 16,
  parameter int FRAC_W      = 8,
  parameter int CENTER_WORD = 15135,
  parameter int HALF_WORD   = 887,
  parameter int KP_GAIN     = 64,
  parameter int KI_GAIN     = 4,
  parameter int LOCK_SHIFT  = 4,
  parameter int LOCK_THRESH = 64,
  parameter int LOCK_COUNT  = 256
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       inValid,
  input  logic signed [SAMPLE_W-1:0] inSample,
  output logic        [PHASE_W-1:0]  phaseOut,
  output logic        [PHASE_W-1:0]  freqWord,
  output logic                       locked
);

  localparam int ACC_W = PHASE_W + FRAC_W + SAMPLE_W + 4;

  dpllStrobes_t            strb;
  logic signed [SAMPLE_W:0] phaseErr;
  logic signed [ACC_W-1:0]  sumOffset;

  dpll_control #(
    .SAMPLE_W(SAMPLE_W), .PHASE_W(PHASE_W), .FRAC_W(FRAC_W),
    .HALF_WORD(HALF_WORD), .LOCK_SHIFT(LOCK_SHIFT),
    .LOCK_THRESH(LOCK_THRESH), .LOCK_COUNT(LOCK_COUNT), .ACC_W(ACC_W)
  ) uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid), .phaseErr(phaseErr),
    .sumOffset(sumOffset), .strb(strb), .locked(locked)
  );

  dpll_datapath #(
    .SAMPLE_W(SAMPLE_W), .PHASE_W(PHASE_W), .FRAC_W(FRAC_W),
    .CENTER_WORD(CENTER_WORD), .HALF_WORD(HALF_WORD),
    .KP_GAIN(KP_GAIN), .KI_GAIN(KI_GAIN), .ACC_W(ACC_W)
  ) uPath (
    .clk(clk), .rst(rst), .strb(strb), .inSample(inSample),
    .phase(phaseOut), .freqWord(freqWord), .phaseErr(phaseErr),
    .sumOffset(sumOffset)
  );

endmodule

// File: tb/sim_dpll_tone_tracker.sv
module sim_dpll_tone_tracker;

  localparam int SW = 12, PW = 16, FW = 8;
  localparam int CW = 4096, HW = 256, KP = 16, KI = 2;
  localparam int LS = 2, LT = 32, LC = 16;

  logic clk = 1'b0, rst = 1'b1, inValid = 1'b0;
  logic signed [SW-1:0] inSample = '0;
  logic [PW-1:0] phaseOut, freqWord;
  logic locked;

  int nChecks = 0, nFails = 0;
  bit doneFlag = 0;
  longint mInteg, mPhase, mWord;

  dpll_tone_tracker #(
    .SAMPLE_W(SW), .PHASE_W(PW), .FRAC_W(FW), .CENTER_WORD(CW),
    .HALF_WORD(HW), .KP_GAIN(KP), .KI_GAIN(KI), .LOCK_SHIFT(LS),
    .LOCK_THRESH(LT), .LOCK_COUNT(LC)
  ) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .phaseOut(phaseOut), .freqWord(freqWord), .locked(locked)
  );

  always #10 clk = ~clk;

  task automatic check(string req, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected loop behaviour written from the requirements
  function automatic longint modelErr(longint s);
    longint top = (mPhase >> (PW - 2)) & 3;
    return (top == 0 || top == 3) ? s : -s;   // R4
  endfunction

  task automatic modelStep(longint s);
    longint e, sum, off;
    e   = modelErr(s);
    sum = mInteg + KI * e;
    off = sum >>> FW;
    if (off > HW || off < -HW) mInteg = longint'(HW) <<< FW;  // R7
    else                       mInteg = sum;                  // R5
    off = (mInteg + KP * e) >>> FW;
    if (off > HW) off = HW;                                    // R6
    if (off < -HW) off = -HW;
    mPhase = (mPhase + mWord) & ((1 << PW) - 1);               // R3
    mWord  = CW + off;
  endtask

  // One valid sample, inputs changed away from the clock edge
  task automatic stepSample(longint s, string req);
    inSample = SW'(s);
    inValid  = 1'b1;
    modelStep(s);
    @(posedge clk); #2;
    inValid = 1'b0;
    check("R3", phaseOut, mPhase);
    check(req, freqWord, mWord);
  endtask

  // Sample magnitude a, signed so that the detector sees error sign sgn
  function automatic longint pickSample(longint a, int sgn);
    longint top = (phaseOut >> (PW - 2)) & 3;
    bit pos = (top == 0 || top == 3);
    return (pos == (sgn > 0)) ? a : -a;
  endfunction

  task automatic tReset();
    rst = 1'b1; inValid = 1'b0;
    @(posedge clk); @(posedge clk); #2;
    rst = 1'b0;
    mInteg = longint'(HW) <<< FW; mPhase = 0; mWord = CW + HW;
    check("R1", phaseOut, 0);
    check("R1", freqWord, CW + HW);
    check("R1", locked, 0);
  endtask

  task automatic tFreeRun();
    tReset();
    for (int k = 0; k < 20; k++) stepSample(0, "R5");
    check("R3", phaseOut, (20 * (CW + HW)) & 16'hFFFF);
  endtask

  task automatic tHold();
    logic [PW-1:0] p0, w0;
    logic l0;
    tReset();
    for (int k = 0; k < 3; k++) stepSample(pickSample(256, -1), "R5");
    p0 = phaseOut; w0 = freqWord; l0 = locked;
    inSample = SW'(-700);
    repeat (5) @(posedge clk);
    #2;
    check("R2", phaseOut, p0);
    check("R2", freqWord, w0);
    check("R2", locked, l0);
  endtask

  task automatic tLock();
    tReset();
    for (int k = 0; k < LC - 1; k++) stepSample(0, "R5");
    check("R8", locked, 0);
    stepSample(0, "R5");
    check("R8", locked, 1);
  endtask

  task automatic tLoudDropsLock();
    tLock();
    // error -256 moves lp to -64, beyond the threshold, without reload
    stepSample(pickSample(256, -1), "R4");
    check("R10", locked, 0);
    check("R10", freqWord, CW + 238);
  endtask

  task automatic tReloadDropsLock();
    tLock();
    // positive error pushes the integrator above the upper edge
    stepSample(pickSample(256, 1), "R7");
    check("R9", locked, 0);
    check("R7", freqWord, CW + HW);
  endtask

  task automatic tSweep();
    tReset();
    for (int k = 1; k <= 260; k++) begin
      stepSample(pickSample(256, -1), "R5");
      if (k == 1)   check("R5", freqWord, CW + 238);
      if (k == 256) check("R6", freqWord, CW - HW);
      if (k == 257) check("R7", freqWord, CW + 240);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!doneFlag) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #5;
    tFreeRun();
    tHold();
    tLock();
    tLoudDropsLock();
    tReloadDropsLock();
    tSweep();
    doneFlag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule